// File: doc/BRIEF.md
# Eight-Bit Reload Timer with Cascade Output

This block is an 8-bit up-counter that restarts from a programmable preset each time it rolls over from all ones to zero. It takes its count pulses from one of seven sources picked by a 3-bit rate code: five decade ticks from a shared divider, an external event pulse and a mains-line tick. A rate code of zero stops counting. Every rollover produces a one-cycle event pulse for outside equipment, sets a sticky flag and can raise an interrupt.

The rollover pulse can also drive a companion 16-bit timer. When the cascade-enable bit is set, the pulse appears on a separate output that the companion timer uses as its count source when its own rate code is zero. Software reaches the block through a small register port with a control/status word, a preset register and a counter register. The preset cannot be written while the timer runs. The counter reads as zero while the timer runs, except when cascade and auto-lengthen are both on. Each 8-bit value sits in the low byte, and the high byte reads as zero.

All tick inputs are single-cycle pulses that are already synchronous to `clk`.

Top module: `rtm8_timer`

## Requirements
- R1: While reset is asserted, the control word, the preset and the counter are zero. `irqOut`, `eventOut`, `cascadeTick`, `forceOtherIrq` and `autoLenOut` are all low.
- R2: The control word holds run-enable in bit 0 and the rate code in bits 3..1. The codes select: 1 = `decadeTick[0]`, 2 = `decadeTick[1]`, 3 = `decadeTick[2]`, 4 = `decadeTick[3]`, 5 = `decadeTick[4]`, 6 = `extEvent`, 7 = `lineTick`. While enabled, the counter advances by one on each pulse of the selected source and ignores pulses on every other source.
- R3: Rate code 0 stops the counter even when run-enable is set. A cleared run-enable also stops the counter.
- R4: On a counted pulse at count 0xFF, the counter reloads the preset value. In the same clock edge the flag (control bit 7) sets. `eventOut` is high for the following cycle.
- R5: `irqOut` is high whenever the flag and the interrupt-enable bit (control bit 6) are both set, or whenever the self-interrupt bit (control bit 9) is set.
- R6: `cascadeTick` pulses together with `eventOut` only when the cascade-enable bit (control bit 5) is set. Otherwise it stays low.
- R7: A write to the preset register (address 1) while run-enable is clear stores the low byte into the preset and also into the counter. A write to the preset register while run-enable is set has no effect.
- R8: Reading the counter register (address 2) returns the count while the timer is stopped. While run-enable is set, the read returns zero unless the cascade-enable and auto-lengthen bits (bits 5 and 4) are both set.
- R9: The counter and preset registers read with the upper byte as zero. Address 3 reads zero. The control word (address 0) reads back every stored bit in its position.
- R10: `forceOtherIrq` follows control bit 10, and `autoLenOut` follows control bit 4.
- R11: A write to the control word loads the flag from data bit 7, so writing 0 clears it. If a rollover happens in the same cycle as such a write, the flag ends up set.
- R12: With a preset of zero, 256 counted pulses elapse between restart and rollover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| decadeTick | input | 5 | Decade tick pulses, fastest in bit 0 |
| extEvent | input | 1 | Synchronised external event pulse |
| lineTick | input | 1 | Mains-line tick pulse |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select: 0 control, 1 preset, 2 counter |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `regAddr` |
| eventOut | output | 1 | One-cycle pulse after each rollover |
| cascadeTick | output | 1 | Rollover pulse for the companion timer |
| irqOut | output | 1 | Interrupt request level |
| forceOtherIrq | output | 1 | Forced interrupt request to the companion timer |
| autoLenOut | output | 1 | Auto-lengthen mode level for the companion timer |

## Verification
The hardest situation to reach is a rollover that lands in the same cycle as a control-word write that clears the flag. The bench first steps the counter to 0xFF. It then drives the tick and the write in one cycle and reads the flag back to confirm that the rollover wins. The read lock on a running counter is exercised both ways: the bench reads the counter while running in plain mode, then in cascade plus auto-lengthen mode. The 256-pulse period is measured by counting pulses until `eventOut` first appears.

// File: rtl/rtm8_pkg.sv
package rtm8_pkg;
  localparam int RATE_W = 3;
  localparam int ADDR_W = 2;

  localparam int BIT_EN          = 0;
  localparam int BIT_RATE_LO     = 1;
  localparam int BIT_AUTO        = 4;
  localparam int BIT_FEED        = 5;
  localparam int BIT_IE          = 6;
  localparam int BIT_FLAG        = 7;
  localparam int BIT_FORCE_OWN   = 9;
  localparam int BIT_FORCE_OTHER = 10;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_CTRL   = 2'd0,
    ADDR_PRESET = 2'd1,
    ADDR_COUNT  = 2'd2,
    ADDR_NONE   = 2'd3
  } regAddr_e;

  typedef struct packed {
    logic step;
    logic reload;
    logic presetWr;
  } dpStrobe_t;
endpackage

// File: rtl/rtm8_ctrl.sv
module rtm8_ctrl
  import rtm8_pkg::*;
#(
  parameter int REG_W      = 16,
  parameter int NUM_DECADE = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_DECADE-1:0] decadeTick,
  input  logic                  extEvent,
  input  logic                  lineTick,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [REG_W-1:0]      wrData,
  input  logic                  atMax,
  output dpStrobe_t             strobe,
  output logic [REG_W-1:0]      statusWord,
  output logic                  runEn,
  output logic                  feedEn,
  output logic                  autoLenEn,
  output logic                  irqOut,
  output logic                  forceOtherIrq
);
  localparam int NUM_SRC  = 1 << RATE_W;
  localparam int EXT_CODE = NUM_DECADE + 1;

  logic              enQ, autoQ, feedQ, ieQ, flagQ, forceOwnQ, forceOtherQ;
  logic [RATE_W-1:0] rateQ;
  logic [NUM_SRC-1:0] srcVec;
  logic              ctrlWr, tickHit;
  logic              unusedWrBits;

  // Source table: code 0 is the stop code, then decades, external, line.
  genvar code;
  generate
    for (code = 0; code < NUM_SRC; code++) begin : g_src
      if (code == 0) begin : g_stop
        assign srcVec[code] = 1'b0;
      end else if (code <= NUM_DECADE) begin : g_dec
        assign srcVec[code] = decadeTick[code-1];
      end else if (code == EXT_CODE) begin : g_ext
        assign srcVec[code] = extEvent;
      end else if (code == NUM_SRC - 1) begin : g_line
        assign srcVec[code] = lineTick;
      end else begin : g_none
        assign srcVec[code] = 1'b0;
      end
    end
  endgenerate

  assign ctrlWr  = wrEn && (regAddr == ADDR_CTRL);
  assign tickHit = enQ && srcVec[rateQ];

  always_comb begin
    strobe          = '0;
    strobe.step     = tickHit && !atMax;
    strobe.reload   = tickHit && atMax;
    strobe.presetWr = wrEn && (regAddr == ADDR_PRESET) && !enQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ         <= 1'b0;
      rateQ       <= '0;
      autoQ       <= 1'b0;
      feedQ       <= 1'b0;
      ieQ         <= 1'b0;
      forceOwnQ   <= 1'b0;
      forceOtherQ <= 1'b0;
    end else if (ctrlWr) begin
      enQ         <= wrData[BIT_EN];
      rateQ       <= wrData[BIT_RATE_LO +: RATE_W];
      autoQ       <= wrData[BIT_AUTO];
      feedQ       <= wrData[BIT_FEED];
      ieQ         <= wrData[BIT_IE];
      forceOwnQ   <= wrData[BIT_FORCE_OWN];
      forceOtherQ <= wrData[BIT_FORCE_OTHER];
    end
  end

  // A rollover outranks a software write of the flag in the same cycle.
  always_ff @(posedge clk) begin
    if (!rstN)              flagQ <= 1'b0;
    else if (strobe.reload) flagQ <= 1'b1;
    else if (ctrlWr)        flagQ <= wrData[BIT_FLAG];
  end

  always_comb begin
    statusWord                           = '0;
    statusWord[BIT_EN]                   = enQ;
    statusWord[BIT_RATE_LO +: RATE_W]    = rateQ;
    statusWord[BIT_AUTO]                 = autoQ;
    statusWord[BIT_FEED]                 = feedQ;
    statusWord[BIT_IE]                   = ieQ;
    statusWord[BIT_FLAG]                 = flagQ;
    statusWord[BIT_FORCE_OWN]            = forceOwnQ;
    statusWord[BIT_FORCE_OTHER]          = forceOtherQ;
  end

  assign runEn         = enQ;
  assign feedEn        = feedQ;
  assign autoLenEn     = autoQ;
  assign irqOut        = (flagQ && ieQ) || forceOwnQ;
  assign forceOtherIrq = forceOtherQ;
  assign unusedWrBits  = ^{wrData[REG_W-1:BIT_FORCE_OTHER+1], wrData[BIT_FLAG+1]};
endmodule

// File: rtl/rtm8_dp.sv
module rtm8_dp
  import rtm8_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [CNT_W-1:0] presetIn,
  output logic [CNT_W-1:0] cntQ,
  output logic [CNT_W-1:0] presetQ,
  output logic             atMax,
  output logic             ovfPulse
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ    <= '0;
      presetQ <= '0;
    end else if (strobe.presetWr) begin
      presetQ <= presetIn;
      cntQ    <= presetIn;
    end else if (strobe.reload) begin
      cntQ    <= presetQ;
    end else if (strobe.step) begin
      cntQ    <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ovfPulse <= 1'b0;
    else       ovfPulse <= strobe.reload;
  end

  assign atMax = &cntQ;
endmodule

// File: rtl/rtm8_timer.sv
module rtm8_timer
  import rtm8_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int REG_W      = 16,
  parameter int NUM_DECADE = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_DECADE-1:0] decadeTick,
  input  logic                  extEvent,
  input  logic                  lineTick,
  input  logic                  wrEn,
  input  logic [1:0]            regAddr,
  input  logic [REG_W-1:0]      wrData,
  output logic [REG_W-1:0]      rdData,
  output logic                  eventOut,
  output logic                  cascadeTick,
  output logic                  irqOut,
  output logic                  forceOtherIrq,
  output logic                  autoLenOut
);
  localparam int PAD_W = REG_W - CNT_W;

  dpStrobe_t        strobe;
  logic [REG_W-1:0] statusWord;
  logic [CNT_W-1:0] cntQ, presetQ;
  logic             atMax, ovfPulse, runEn, feedEn, autoLenEn, countVisible;

  rtm8_ctrl #(.REG_W(REG_W), .NUM_DECADE(NUM_DECADE)) ctrl_i (
    .clk(clk), .rstN(rstN), .decadeTick(decadeTick), .extEvent(extEvent),
    .lineTick(lineTick), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .atMax(atMax), .strobe(strobe), .statusWord(statusWord), .runEn(runEn),
    .feedEn(feedEn), .autoLenEn(autoLenEn), .irqOut(irqOut),
    .forceOtherIrq(forceOtherIrq)
  );

  rtm8_dp #(.CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .presetIn(wrData[CNT_W-1:0]),
    .cntQ(cntQ), .presetQ(presetQ), .atMax(atMax), .ovfPulse(ovfPulse)
  );

  assign countVisible = !runEn || (feedEn && autoLenEn);

  always_comb begin
    unique case (regAddr)
      ADDR_CTRL:   rdData = statusWord;
      ADDR_PRESET: rdData = {{PAD_W{1'b0}}, presetQ};
      ADDR_COUNT:  rdData = countVisible ? {{PAD_W{1'b0}}, cntQ} : '0;
      default:     rdData = '0;
    endcase
  end

  assign eventOut    = ovfPulse;
  assign cascadeTick = ovfPulse && feedEn;
  assign autoLenOut  = autoLenEn;
endmodule

// File: rtl/rtm8_timer_chk.sv
module rtm8_timer_chk #(
  parameter int CNT_W = 8,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             eventOut,
  input logic             cascadeTick,
  input logic             irqOut,
  input logic             wrEn,
  input logic [1:0]       regAddr,
  input logic [REG_W-1:0] rdData,
  input logic [REG_W-1:0] statusWord,
  input logic [CNT_W-1:0] cntQ,
  input logic [CNT_W-1:0] presetQ,
  input logic             runEn
);
  a_r4_reload_value: assert property (@(posedge clk) disable iff (!rstN)
    eventOut |-> cntQ == presetQ);

  a_r4_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    eventOut |-> statusWord[7]);

  a_r3_stopped_holds: assert property (@(posedge clk) disable iff (!rstN)
    ((statusWord[3:1] == 3'd0 || !statusWord[0]) && !(wrEn && regAddr == 2'd1))
      |=> $stable(cntQ));

  a_r7_preset_locked: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && wrEn && regAddr == 2'd1) |=> $stable(presetQ));

  a_r5_irq_raised: assert property (@(posedge clk) disable iff (!rstN)
    (statusWord[7] && statusWord[6]) |-> irqOut);

  a_r6_cascade_gated: assert property (@(posedge clk) disable iff (!rstN)
    cascadeTick |-> (eventOut && statusWord[5]));

  a_r8_read_lock: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == 2'd2 && runEn && !(statusWord[5] && statusWord[4]))
      |-> rdData == '0);

  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr != 2'd0) |-> rdData[REG_W-1:CNT_W] == '0);
endmodule

bind rtm8_timer rtm8_timer_chk #(.CNT_W(CNT_W), .REG_W(REG_W)) chk_i (
  .clk(clk), .rstN(rstN), .eventOut(eventOut), .cascadeTick(cascadeTick),
  .irqOut(irqOut), .wrEn(wrEn), .regAddr(regAddr), .rdData(rdData),
  .statusWord(statusWord), .cntQ(cntQ), .presetQ(presetQ), .runEn(runEn)
);

// File: tb/rtm8_timer_tb.sv
module rtm8_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 33;
  localparam logic [1:0] OP_WR = 2'd0, OP_TK = 2'd1, OP_RD = 2'd2;

  // Vector layout: {op, addr, data, expected, requirement number}
  localparam logic [39:0] VEC [NVEC] = '{
    {OP_WR, 2'd1, 16'h00FC, 16'h0000, 4'd7},   // R7 preset while stopped
    {OP_RD, 2'd2, 16'h0000, 16'h00FC, 4'd7},   // R7 counter loaded too
    {OP_RD, 2'd1, 16'h0000, 16'h00FC, 4'd9},
    {OP_WR, 2'd0, 16'h0003, 16'h0000, 4'd2},   // R2 run, code 1
    {OP_TK, 2'd0, 16'h0001, 16'h0000, 4'd2},
    {OP_TK, 2'd0, 16'h0002, 16'h0000, 4'd2},   // other decade ignored
    {OP_TK, 2'd0, 16'h0020, 16'h0000, 4'd2},   // external ignored
    {OP_RD, 2'd2, 16'h0000, 16'h0000, 4'd8},   // R8 locked read
    {OP_WR, 2'd1, 16'h0011, 16'h0000, 4'd7},   // ignored while running
    {OP_WR, 2'd0, 16'h0002, 16'h0000, 4'd3},   // stop
    {OP_RD, 2'd2, 16'h0000, 16'h00FD, 4'd2},
    {OP_RD, 2'd1, 16'h0000, 16'h00FC, 4'd7},
    {OP_RD, 2'd0, 16'h0000, 16'h0002, 4'd9},
    {OP_WR, 2'd0, 16'h000D, 16'h0000, 4'd2},   // code 6 external
    {OP_TK, 2'd0, 16'h0020, 16'h0000, 4'd2},
    {OP_TK, 2'd0, 16'h0040, 16'h0000, 4'd2},   // line ignored
    {OP_WR, 2'd0, 16'h003D, 16'h0000, 4'd8},   // cascade + auto-lengthen
    {OP_RD, 2'd2, 16'h0000, 16'h00FE, 4'd8},   // readable while running
    {OP_WR, 2'd0, 16'h000F, 16'h0000, 4'd2},   // code 7 line
    {OP_TK, 2'd0, 16'h0040, 16'h0000, 4'd2},
    {OP_TK, 2'd0, 16'h0040, 16'h0000, 4'd4},   // rollover
    {OP_RD, 2'd0, 16'h0000, 16'h008F, 4'd4},   // flag set
    {OP_WR, 2'd0, 16'h0000, 16'h0000, 4'd11},  // clear flag, stop
    {OP_RD, 2'd2, 16'h0000, 16'h00FC, 4'd4},   // reloaded
    {OP_RD, 2'd0, 16'h0000, 16'h0000, 4'd11},
    {OP_WR, 2'd0, 16'h0001, 16'h0000, 4'd3},   // enabled, code 0
    {OP_TK, 2'd0, 16'h007F, 16'h0000, 4'd3},
    {OP_WR, 2'd0, 16'h0000, 16'h0000, 4'd3},
    {OP_RD, 2'd2, 16'h0000, 16'h00FC, 4'd3},   // R3 no movement
    {OP_RD, 2'd3, 16'h0000, 16'h0000, 4'd9},
    {OP_WR, 2'd1, 16'hAB12, 16'h0000, 4'd9},
    {OP_RD, 2'd1, 16'h0000, 16'h0012, 4'd9},   // R9 upper byte zero
    {OP_RD, 2'd2, 16'h0000, 16'h0012, 4'd9}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [6:0]  tickV = '0;
  logic        wrEn = 1'b0;
  logic [1:0]  regAddr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic        eventOut, cascadeTick, irqOut, forceOtherIrq, autoLenOut;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtm8_timer dut_i (
    .clk(clk), .rstN(rstN), .decadeTick(tickV[4:0]), .extEvent(tickV[5]),
    .lineTick(tickV[6]), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .eventOut(eventOut), .cascadeTick(cascadeTick),
    .irqOut(irqOut), .forceOtherIrq(forceOtherIrq), .autoLenOut(autoLenOut)
  );

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic tick(input logic [6:0] m);
    @(negedge clk); tickV = m;
    @(negedge clk); tickV = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [15:0] exp, input string req);
    @(negedge clk); regAddr = a; #1;
    check(rdData == exp, req, rdData, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({eventOut, cascadeTick, irqOut, forceOtherIrq, autoLenOut} == 5'b0,
          "R1 outputs", {11'b0, eventOut, cascadeTick, irqOut, forceOtherIrq, autoLenOut}, 16'h0);
    @(negedge clk); rstN = 1'b1;
    rd(2'd0, 16'h0000, "R1 ctrl");
    rd(2'd1, 16'h0000, "R1 preset");
    rd(2'd2, 16'h0000, "R1 counter");

    for (int i = 0; i < NVEC; i++) begin
      logic [1:0] op = VEC[i][39:38];
      logic [1:0] a = VEC[i][37:36];
      string tag = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
      case (op)
        OP_WR: wr(a, VEC[i][35:20]);
        OP_TK: tick(VEC[i][26:20]);
        default: rd(a, VEC[i][19:4], tag);
      endcase
    end

    // R4/R5/R6: rollover with cascade and interrupt enabled
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h00FE);
    wr(2'd0, 16'h0063);
    tick(7'h01);
    check(!eventOut, "R4 no pulse before rollover", {15'b0, eventOut}, 16'h0);
    tick(7'h01);
    check(eventOut, "R4 event pulse", {15'b0, eventOut}, 16'h1);
    check(cascadeTick, "R6 cascade with feed", {15'b0, cascadeTick}, 16'h1);
    check(irqOut, "R5 irq from flag", {15'b0, irqOut}, 16'h1);
    @(negedge clk);
    check(!eventOut && !cascadeTick, "R4 pulse one cycle",
          {14'b0, eventOut, cascadeTick}, 16'h0);
    // R11 clear flag, R6 no cascade without feed
    wr(2'd0, 16'h0043);
    check(!irqOut, "R11 flag cleared", {15'b0, irqOut}, 16'h0);
    tick(7'h01);
    tick(7'h01);
    check(eventOut && !cascadeTick, "R6 cascade gated off",
          {14'b0, eventOut, cascadeTick}, 16'h2);
    // R11 rollover and flag-clearing write in the same cycle
    wr(2'd0, 16'h0043);
    tick(7'h01);
    @(negedge clk); tickV = 7'h01; wrEn = 1'b1; regAddr = 2'd0; wrData = 16'h0043;
    @(negedge clk); tickV = '0; wrEn = 1'b0;
    rd(2'd0, 16'h00C3, "R11 rollover wins");

    // R5 forced interrupt, R10 maintenance levels
    wr(2'd0, 16'h0200);
    check(irqOut, "R5 forced irq", {15'b0, irqOut}, 16'h1);
    wr(2'd0, 16'h0400);
    check(!irqOut && forceOtherIrq, "R10 force other",
          {14'b0, irqOut, forceOtherIrq}, 16'h1);
    wr(2'd0, 16'h0010);
    check(autoLenOut && !forceOtherIrq, "R10 auto-lengthen level",
          {14'b0, autoLenOut, forceOtherIrq}, 16'h2);

    // R12 preset zero gives 256 pulses
    wr(2'd0, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd0, 16'h0003);
    n = 0;
    for (int i = 1; i <= 300; i++) begin
      tick(7'h01);
      if (eventOut) begin n = i; break; end
    end
    check(n == 256, "R12 period", n[15:0], 16'd256);

    // R1 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); regAddr = 2'd0; #1;
    check(rdData == 16'h0 && !irqOut, "R1 reset mid-run", rdData, 16'h0);
    @(negedge clk); rstN = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule